// File: doc/BRIEF.md
# Masked Additive-to-XOR Share Converter

This block takes a 32-bit word protected by an additive mask, `a = x + r (mod 2^W)`, and re-masks it as `b = x ^ r` under the same mask `r`. The unmasked value `x` never appears on any internal net. Every carry of the sum `x + r` moves through the logic XOR-masked by a fresh random bit `q`. The low carry comes from a single masked gate. All higher carries come from a chain of 2:1 selectors, whose data inputs are masked by `q` and whose selects are `a_j ^ r_j`.

The block sits between the additive part and the XOR part of a masked hash datapath. It runs after additions have produced a sum under an additive mask, and before the logic functions that expect XOR masks. The result is registered: it appears one clock after the inputs are applied. Mask and random-bit generation belong to the surrounding datapath.

Top module: `a2b_masked_conv`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first clock edge, `bmask_val_o` is zero.
- R2: `bmask_val_o` is registered. It reflects the inputs sampled at the previous rising edge of `clk_i`.
- R3: `bmask_val_o ^ mask_i` equals `amask_val_i - mask_i` modulo 2^W, with both input values taken from the previous edge.
- R4: Bit 0 of `bmask_val_o` equals bit 0 of the previous `amask_val_i`, because no carry enters bit 0.
- R5: With a zero mask, `bmask_val_o` equals the previous `amask_val_i`.
- R6: `rand_bit_i` does not change the result. For the same `amask_val_i` and `mask_i`, both values of `rand_bit_i` give the same `bmask_val_o`.
- R7: A carry generated at bit 0 propagates across the whole width. With `amask_val_i` = 0 and `mask_i` = 1, `bmask_val_o` is 32'hFFFF_FFFE.
- R8: Masking any `b` with `r` additively, as `((b ^ r) + r) mod 2^W`, and then converting returns `b` exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| amask_val_i | input | W | Value under additive mask (x + r) |
| mask_i | input | W | Mask r shared by input and output |
| rand_bit_i | input | 1 | Random bit that masks the carry chain |
| bmask_val_o | output | W | Value under XOR mask (x ^ r), registered |

## Verification
The checker tests on every cycle that the registered result, XORed with the previous mask, equals the previous additive value minus that mask. It also checks that bit 0 passes through untouched, that a zero mask leaves the value unchanged, and that the full-width borrow from a unit mask behaves as required. Two properties need paired stimulus, so only the bench scenarios can show them: that the random carry mask cancels for either value of the random bit, and that a Boolean-to-additive step followed by this converter returns the original XOR-masked word.

// File: rtl/a2b_pkg.sv
package a2b_pkg;
  localparam int unsigned A2B_WIDTH = 32;
  localparam int unsigned A2B_LAT   = 1;
endpackage

// File: rtl/a2b_carry_seed.sv
// Masked carry out of bit 0: (r0 & ~a0) ^ q. The select a0 ^ r0 is never formed.
module a2b_carry_seed (
  input  logic amask_b0_i,
  input  logic mask_b0_i,
  input  logic rand_i,
  output logic carry_m_o
);
  always_comb carry_m_o = (mask_b0_i & ~amask_b0_i) ^ rand_i;
endmodule

// File: rtl/a2b_carry_mux.sv
// One masked carry stage: select 1 -> masked r_j, select 0 -> masked incoming carry.
module a2b_carry_mux (
  input  logic sel_i,
  input  logic rmask_m_i,
  input  logic carry_m_i,
  output logic carry_m_o
);
  always_comb carry_m_o = sel_i ? rmask_m_i : carry_m_i;
endmodule

// File: rtl/a2b_chain.sv
module a2b_chain #(
  parameter int unsigned W = a2b_pkg::A2B_WIDTH
) (
  input  logic [W-1:0] amask_i,
  input  logic [W-1:0] mask_i,
  input  logic         rand_i,
  output logic [W-1:0] bmask_o
);
  localparam int unsigned NCARRY = W - 1;

  // carry_m[j] = c_j ^ q, for j = 0 .. W-2
  logic [NCARRY-1:0] carry_m;
  logic [W-1:0]      rmask_m;

  always_comb rmask_m = mask_i ^ {W{rand_i}};

  a2b_carry_seed i_seed (
    .amask_b0_i (amask_i[0]),
    .mask_b0_i  (mask_i[0]),
    .rand_i     (rand_i),
    .carry_m_o  (carry_m[0])
  );

  for (genvar j = 1; j < NCARRY; j++) begin : g_stage
    logic sel;
    always_comb sel = amask_i[j] ^ mask_i[j];
    a2b_carry_mux i_mux (
      .sel_i     (sel),
      .rmask_m_i (rmask_m[j]),
      .carry_m_i (carry_m[j-1]),
      .carry_m_o (carry_m[j])
    );
  end

  always_comb bmask_o[0] = amask_i[0];

  for (genvar j = 1; j < W; j++) begin : g_out
    // mask q removed last, after the masked carry has been folded in
    always_comb bmask_o[j] = (amask_i[j] ^ carry_m[j-1]) ^ rand_i;
  end
endmodule

// File: rtl/a2b_masked_conv.sv
module a2b_masked_conv #(
  parameter int unsigned W = a2b_pkg::A2B_WIDTH
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] amask_val_i,
  input  logic [W-1:0] mask_i,
  input  logic         rand_bit_i,
  output logic [W-1:0] bmask_val_o
);
  logic [W-1:0] conv_d;
  logic [W-1:0] conv_q;

  a2b_chain #(.W(W)) i_chain (
    .amask_i (amask_val_i),
    .mask_i  (mask_i),
    .rand_i  (rand_bit_i),
    .bmask_o (conv_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) conv_q <= '0;
    else         conv_q <= conv_d;
  end

  assign bmask_val_o = conv_q;
endmodule

// File: rtl/a2b_masked_conv_chk.sv
module a2b_masked_conv_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] amask_val_i,
  input logic [W-1:0] mask_i,
  input logic [W-1:0] bmask_val_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  // R3
  sub_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> ((bmask_val_o ^ $past(mask_i)) == ($past(amask_val_i) - $past(mask_i))));

  // R4
  bit0_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (bmask_val_o[0] == $past(amask_val_i[0])));

  // R5
  zero_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && ($past(mask_i) == '0)) |-> (bmask_val_o == $past(amask_val_i)));

  // R7
  full_borrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && ($past(mask_i) == W'(1)) && ($past(amask_val_i) == '0))
      |-> (bmask_val_o == ~W'(1)));

  // R1
  always_ff @(posedge clk_i) begin
    if (!seen_q) rst_zero_chk: assert (bmask_val_o == '0);
  end
endmodule

bind a2b_masked_conv a2b_masked_conv_chk #(.W(W)) i_a2b_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .amask_val_i (amask_val_i),
  .mask_i      (mask_i),
  .bmask_val_o (bmask_val_o)
);

// File: tb/test_a2b_masked_conv.sv
module test_a2b_masked_conv;
  localparam int unsigned W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] r_in = '0;
  logic         q_in = 1'b0;
  logic [W-1:0] b_out;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  a2b_masked_conv #(.W(W)) i_a2b_masked_conv (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .amask_val_i (a_in),
    .mask_i      (r_in),
    .rand_bit_i  (q_in),
    .bmask_val_o (b_out)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, registered result sampled at following negedge
  task automatic convert(input logic [W-1:0] a, input logic [W-1:0] r, input logic q,
                         output logic [W-1:0] res);
    @(negedge clk);
    a_in = a; r_in = r; q_in = q;
    @(negedge clk);
    res = b_out;
  endtask

  function automatic logic [W-1:0] expect_b(input logic [W-1:0] a, input logic [W-1:0] r);
    return (a - r) ^ r;
  endfunction

  task automatic t_reset();
    a_in = 32'hDEAD_BEEF; r_in = 32'h1234_5678; q_in = 1'b1;
    #5;
    check(b_out == '0, "R1 during reset", b_out, '0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    #2;
    check(b_out == '0, "R1 after release", b_out, '0);
  endtask

  task automatic t_latency();
    logic [W-1:0] res;
    convert(32'h0000_00FF, 32'h0000_0001, 1'b0, res);
    @(negedge clk);
    a_in = 32'h0000_0010; r_in = 32'h0; q_in = 1'b0;
    #1;
    check(b_out == expect_b(32'h0000_00FF, 32'h1), "R2 holds until edge", b_out,
          expect_b(32'h0000_00FF, 32'h1));
    @(negedge clk);
    check(b_out == 32'h0000_0010, "R2 updates after edge", b_out, 32'h0000_0010);
  endtask

  task automatic t_random();
    logic [W-1:0] res, a, r;
    for (int i = 0; i < 200; i++) begin
      a = $urandom(); r = $urandom();
      convert(a, r, 1'($urandom()), res);
      check(res == expect_b(a, r), "R3 random", res, expect_b(a, r));
      check(res[0] == a[0], "R4 bit0", {31'b0, res[0]}, {31'b0, a[0]});
    end
  endtask

  task automatic t_zero_mask();
    logic [W-1:0] res;
    logic [W-1:0] vals [4] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h5A5A_A5A5};
    foreach (vals[i]) begin
      convert(vals[i], '0, 1'(i), res);
      check(res == vals[i], "R5 zero mask", res, vals[i]);
    end
  endtask

  task automatic t_q_indep();
    logic [W-1:0] r0, r1, a, r;
    for (int i = 0; i < 20; i++) begin
      a = $urandom(); r = $urandom();
      convert(a, r, 1'b0, r0);
      convert(a, r, 1'b1, r1);
      check(r0 == r1, "R6 random bit ignored", r1, r0);
    end
  endtask

  task automatic t_corners();
    logic [W-1:0] res;
    convert(32'h0, 32'h1, 1'b0, res);
    check(res == 32'hFFFF_FFFE, "R7 full borrow q0", res, 32'hFFFF_FFFE);
    convert(32'h0, 32'h1, 1'b1, res);
    check(res == 32'hFFFF_FFFE, "R7 full borrow q1", res, 32'hFFFF_FFFE);
    convert(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, res);
    check(res == expect_b(32'hFFFF_FFFF, 32'hFFFF_FFFF), "R3 all ones", res,
          expect_b(32'hFFFF_FFFF, 32'hFFFF_FFFF));
    convert(32'h8000_0000, 32'h8000_0000, 1'b0, res);
    check(res == 32'h8000_0000, "R3 top bit", res, 32'h8000_0000);
  endtask

  task automatic t_roundtrip();
    logic [W-1:0] res, b, r, a;
    for (int i = 0; i < 100; i++) begin
      b = $urandom(); r = (i == 0) ? 32'hFFFF_FFFF : $urandom();
      a = (b ^ r) + r;
      convert(a, r, 1'($urandom()), res);
      check(res == b, "R8 round trip", res, b);
    end
  endtask

  initial begin
    t_reset();
    t_latency();
    t_zero_mask();
    t_corners();
    t_q_indep();
    t_random();
    t_roundtrip();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule